// File: doc/BRIEF.md
# Binary Add/Subtract-with-Carry Arithmetic Unit

This block is the arithmetic engine of an 8-bit accumulator machine. It takes the accumulator value, a memory or immediate operand, the current carry bit and an operation select. It returns an 8-bit result together with four condition flags: carry, signed overflow, negative and zero. Subtraction has no separate subtractor. The operand is bit-inverted and fed into the same carry-propagating adder as an addition, so the incoming carry acts as "no borrow pending". After a subtract, a carry of one means no borrow was needed. Arithmetic is always plain binary.

The combinational result and flags are visible at all times. A status register copies them on any clock edge where the latch strobe is high, and holds them otherwise. The surrounding sequencer uses this register as the architectural flag state.

Top module: `alu_arith_core`

## Requirements
- R1: With op_sel = 0 (add), sum_out equals (acc_in + opnd_in + carry_in) mod 256.
- R2: With op_sel = 1 (subtract), sum_out equals (acc_in + (opnd_in XOR 0xFF) + carry_in) mod 256, produced by the same adder as R1.
- R3: carry_out is bit 8 of the 9-bit sum used in R1 or R2. It is set exactly when that sum is 256 or more, so after a subtract a set carry means no borrow occurred.
- R4: neg_out equals bit 7 of sum_out.
- R5: zero_out is 1 exactly when sum_out is 0x00.
- R6: ovf_out is 1 exactly when the two adder inputs (acc_in and the possibly inverted operand) have equal bit 7 and sum_out bit 7 differs from them. Equivalently, the two's-complement sum does not fit in 8 signed bits.
- R7: Subtract of 0x41 from 0xC1 with carry_in = 1 gives 0xC1 + 0xBE + 1 = 0x180. The outputs are sum_out = 0x80, carry 1, negative 1, overflow 0 and zero 0.
- R8: Subtract of 0xF0 from 0x10 with carry_in = 1 gives sum_out = 0x20 with carry 0, marking a borrow.
- R9: A subtract with carry_in = 0 yields one less, modulo 256, than the same subtract with carry_in = 1.
- R10: On a clock edge with rst = 1, all reg_* outputs become 0. Otherwise, on an edge with latch_en = 1, reg_sum and the four reg flags take the values of sum_out and the flags just before that edge. With latch_en = 0 they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst | input | 1 | Synchronous active-high reset of the status register |
| op_sel | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry (for subtract: 1 = no borrow) |
| latch_en | input | 1 | Capture result and flags at the next edge |
| sum_out | output | 8 | Combinational result |
| carry_out | output | 1 | Combinational carry flag |
| ovf_out | output | 1 | Combinational signed overflow flag |
| neg_out | output | 1 | Combinational negative flag |
| zero_out | output | 1 | Combinational zero flag |
| reg_sum | output | 8 | Latched result |
| reg_carry | output | 1 | Latched carry flag |
| reg_ovf | output | 1 | Latched overflow flag |
| reg_neg | output | 1 | Latched negative flag |
| reg_zero | output | 1 | Latched zero flag |

## Verification
The datapath has no state, so a broken carry link, a wrong inversion or a bad flag term appears on sum_out or a flag as soon as the inputs settle. Sweeping every accumulator, operand, carry and operation value exposes it on the first vector that exercises the faulty bit. A fault in the status register shows one edge later. It appears as a stale value where a capture was requested, or as a changed value where latch_en was low. The register is therefore checked after reset, after a capture and across a hold cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic {
        OP_ADC = 1'b0,
        OP_SBC = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic neg;
        logic zero;
    } alu_flags_t;

    localparam alu_flags_t FLAGS_CLEAR = '{carry: 1'b0, ovf: 1'b0, neg: 1'b0, zero: 1'b0};

    // Signed overflow from the sign bits of both adder inputs and of the result
    function automatic logic signed_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
        return (a_msb == b_msb) && (r_msb != a_msb);
    endfunction

endpackage

// File: rtl/alu_opnd_cond.sv
module alu_opnd_cond
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   opnd,
    output logic [WIDTH-1:0]   opnd_cond
);
    logic invert;
    assign invert = (op == OP_SBC);

    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign opnd_cond[i] = opnd[i] ^ invert;
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] s,
    output logic             cout
);
    logic [WIDTH:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic p;
        assign p          = x[i] ^ y[i];
        assign s[i]       = p ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (p & chain[i]);
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [WIDTH-1:0] s,
    input  logic             cout,
    output alu_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.carry = cout;
        flags.ovf   = signed_ovf(x[MSB], y[MSB], s[MSB]);
        flags.neg   = s[MSB];
        flags.zero  = (s == '0);
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d_sum,
    input  alu_flags_t       d_flags,
    output logic [WIDTH-1:0] q_sum,
    output alu_flags_t       q_flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_sum   <= '0;
            q_flags <= FLAGS_CLEAR;
        end else if (en) begin
            q_sum   <= d_sum;
            q_flags <= d_flags;
        end
    end

    // R10
    st_capture_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (q_sum == $past(d_sum)) && (q_flags == $past(d_flags)));

    // R10
    st_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q_sum) && $stable(q_flags));

    // R10
    st_reset_chk: assert property (@(posedge clk)
        rst |=> (q_sum == '0) && (q_flags == FLAGS_CLEAR));
endmodule

// File: rtl/alu_arith_core.sv
module alu_arith_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_sel,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opnd_in,
    input  logic             carry_in,
    input  logic             latch_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out,
    output logic             neg_out,
    output logic             zero_out,
    output logic [WIDTH-1:0] reg_sum,
    output logic             reg_carry,
    output logic             reg_ovf,
    output logic             reg_neg,
    output logic             reg_zero
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] opnd_c;
    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    alu_flags_t       flags_w;
    alu_flags_t       flags_q;

    assign op = alu_op_e'(op_sel);

    alu_opnd_cond #(.WIDTH(WIDTH)) u_cond (
        .op        (op),
        .opnd      (opnd_in),
        .opnd_cond (opnd_c)
    );

    alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x    (acc_in),
        .y    (opnd_c),
        .cin  (carry_in),
        .s    (sum_w),
        .cout (cout_w)
    );

    alu_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .x     (acc_in),
        .y     (opnd_c),
        .s     (sum_w),
        .cout  (cout_w),
        .flags (flags_w)
    );

    alu_status_reg #(.WIDTH(WIDTH)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .en      (latch_en),
        .d_sum   (sum_w),
        .d_flags (flags_w),
        .q_sum   (reg_sum),
        .q_flags (flags_q)
    );

    assign sum_out   = sum_w;
    assign carry_out = flags_w.carry;
    assign ovf_out   = flags_w.ovf;
    assign neg_out   = flags_w.neg;
    assign zero_out  = flags_w.zero;

    assign reg_carry = flags_q.carry;
    assign reg_ovf   = flags_q.ovf;
    assign reg_neg   = flags_q.neg;
    assign reg_zero  = flags_q.zero;

    // R1
    add_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 1'b0 && !carry_out) |-> (sum_out >= acc_in));

    // R3
    sub_noborrow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 1'b1 && carry_out) |-> (acc_in >= opnd_in));

    // R3
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 1'b1 && !carry_out) |-> (acc_in <= opnd_in));

    // R5
    zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
        zero_out |-> !neg_out);

    // R6
    ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_out |-> (neg_out != acc_in[MSB]));
endmodule

// File: tb/sim_alu_arith_core.sv
module sim_alu_arith_core;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_sel = 1'b0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       carry_in = 1'b0;
    logic       latch_en = 1'b0;
    logic [7:0] sum_out, reg_sum;
    logic       carry_out, ovf_out, neg_out, zero_out;
    logic       reg_carry, reg_ovf, reg_neg, reg_zero;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_arith_core u0 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
        .carry_in(carry_in), .latch_en(latch_en),
        .sum_out(sum_out), .carry_out(carry_out), .ovf_out(ovf_out),
        .neg_out(neg_out), .zero_out(zero_out),
        .reg_sum(reg_sum), .reg_carry(reg_carry), .reg_ovf(reg_ovf),
        .reg_neg(reg_neg), .reg_zero(reg_zero)
    );

    // packs {sum, carry, ovf, neg, zero}
    function automatic logic [11:0] ref_model(input int op, input int a, input int m, input int c);
        int b, tot, sa, sb, sr;
        logic [7:0] r;
        b   = op ? (255 - m) : m;
        tot = a + b + c;
        r   = 8'(tot % 256);
        sa  = (a >= 128) ? a - 256 : a;
        sb  = (b >= 128) ? b - 256 : b;
        sr  = sa + sb + c;
        return {r, (tot >= 256), (sr > 127 || sr < -128), r[7], (r == 8'h00)};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got sum=%02h c=%b v=%b n=%b z=%b, expected sum=%02h c=%b v=%b n=%b z=%b",
                     req, act[11:4], act[3], act[2], act[1], act[0],
                     exp[11:4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [11:0] comb_out();
        return {sum_out, carry_out, ovf_out, neg_out, zero_out};
    endfunction

    function automatic logic [11:0] reg_out();
        return {reg_sum, reg_carry, reg_ovf, reg_neg, reg_zero};
    endfunction

    task automatic apply(input int op, input int a, input int m, input int c);
        op_sel = op[0]; acc_in = a[7:0]; opnd_in = m[7:0]; carry_in = c[0];
        #1;
    endtask

    initial begin : wdog
        #(CLK_PERIOD * WDOG_CYCLES);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] hi, lo;
        // R10 reset state
        repeat (2) @(negedge clk);
        check("R10 reset", reg_out(), 12'h000);
        rst = 1'b0;

        // R7 and R8 named cases
        apply(1, 8'hC1, 8'h41, 1);
        check("R7", comb_out(), {8'h80, 1'b1, 1'b0, 1'b1, 1'b0});
        apply(1, 8'h10, 8'hF0, 1);
        check("R8", comb_out(), {8'h20, 1'b0, 1'b0, 1'b0, 1'b0});

        // R9 clear carry-in subtracts one more
        apply(1, 8'h50, 8'h20, 1); hi = comb_out();
        apply(1, 8'h50, 8'h20, 0); lo = comb_out();
        check("R9", {lo[11:4], 4'h0}, {hi[11:4] - 8'd1, 4'h0});
        apply(1, 8'h00, 8'h00, 0);
        check("R9 wrap", comb_out(), {8'hFF, 1'b0, 1'b0, 1'b1, 1'b0});

        // R6 boundary: 0x7F + 0x01 and 0x80 - 0x01
        apply(0, 8'h7F, 8'h01, 0);
        check("R6 add", comb_out(), {8'h80, 1'b0, 1'b1, 1'b1, 1'b0});
        apply(1, 8'h80, 8'h01, 1);
        check("R6 sub", comb_out(), {8'h7F, 1'b1, 1'b1, 1'b0, 1'b0});

        // R1..R6 exhaustive sweep of both operations
        for (int op = 0; op < 2; op++)
            for (int a = 0; a < 256; a++)
                for (int m = 0; m < 256; m++)
                    for (int c = 0; c < 2; c++) begin
                        apply(op, a, m, c);
                        check(op ? "R2 R3 R4 R5 R6 sub" : "R1 R3 R4 R5 R6 add",
                              comb_out(), ref_model(op, a, m, c));
                    end

        // R10 capture, hold, capture
        @(negedge clk);
        op_sel = 1'b1; acc_in = 8'hC1; opnd_in = 8'h41; carry_in = 1'b1; latch_en = 1'b1;
        @(negedge clk);
        check("R10 capture", reg_out(), {8'h80, 1'b1, 1'b0, 1'b1, 1'b0});
        latch_en = 1'b0; op_sel = 1'b0; acc_in = 8'h80; opnd_in = 8'h80; carry_in = 1'b0;
        @(negedge clk);
        check("R10 hold", reg_out(), {8'h80, 1'b1, 1'b0, 1'b1, 1'b0});
        latch_en = 1'b1;
        @(negedge clk);
        check("R10 capture2", reg_out(), {8'h00, 1'b1, 1'b1, 1'b0, 1'b1});
        latch_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset2", reg_out(), 12'h000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule